// File: doc/BRIEF.md
# Branch History Table Predictor

This block gives the fetch stage a guess about the instruction it is fetching: is it a branch that will be taken, and if so, where does it go? The guess comes from a direct-mapped table. The word-aligned fetch PC supplies the index from its low bits, and the bits above the index form a tag. Each entry holds a valid bit, a tag, a branch target address and a prediction state. A lookup is purely combinational. In the same cycle it returns a hit flag, a taken prediction, the stored target and the next fetch address.

When a branch resolves later in the pipeline, the update port writes the real outcome and target back into the table:

- If the branch already owns its entry, the prediction state moves toward the outcome and the stored target is refreshed.
- Otherwise the branch claims the entry. This evicts any other branch that shares the index. The new entry starts in a weak state that leans toward the resolved outcome.

A parameter selects between a two-bit saturating counter and a one-bit last-outcome state. Squashing wrong-path instructions and computing branch targets are left to the surrounding pipeline.

Top module: `bht_predictor`

## Requirements
- R1: A lookup hits only when the entry at index PC[IDX_W+1:2] is valid and its tag equals PC[ADDR_W-1:IDX_W+2]. A different PC mapping to the same index misses.
- R2: In two-bit mode the state codes are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. A hit predicts taken exactly when bit 1 of the state is 1.
- R3: On a miss, or on a not-taken hit, lk_taken is 0 and lk_next_pc is lk_pc+4. On a taken hit, lk_next_pc is the stored target.
- R4: An update that hits moves the two-bit state up by one on taken and down by one on not-taken. The state holds at 11 and at 00.
- R5: An update that misses allocates the entry with the new tag and target. The entry becomes valid with state 10 if taken and 01 if not taken.
- R6: Every update writes its target into the entry. lk_target shows the stored target on a hit and 0 on a miss.
- R7: A lookup in the same cycle as an update to the same entry returns the contents from before that update. The new contents appear from the next cycle.
- R8: A low rst_n at a clock edge invalidates every entry, so all later lookups miss until a new allocation.
- R9: With ONE_BIT=1 the state is one bit (0 not taken, 1 taken). Every update, whether it allocates or hits, sets the state to the resolved outcome.
- R10: For a loop branch of three iterations (taken, taken, not taken) replayed several times, after the first pass the two-bit mode mispredicts only the exit. The one-bit mode mispredicts both the first iteration and the exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | ADDR_W | Fetch PC to look up |
| lk_hit | output | 1 | Lookup found a matching valid entry |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | ADDR_W | Stored target on hit, else 0 |
| lk_next_pc | output | ADDR_W | Predicted next fetch address |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | ADDR_W | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome |
| up_target | input | ADDR_W | Resolved target address |

## Verification
The assertions check on every cycle the properties that hold for any single lookup or update:

- a miss never predicts taken and falls through to PC+4;
- an update validates its entry;
- an allocation starts in the weak state that matches the outcome;
- the counter steps by one and saturates at both ends.

Some behaviours depend on the order of events, and only the bench's scenarios can show them:

- the exact sequence of states under mixed outcomes;
- eviction by an aliasing tag;
- the old-contents view of a same-cycle lookup and update;
- invalidation by reset;
- the different misprediction patterns of the two modes on a short loop.

// File: rtl/bht_pkg.sv
// Package bht_pkg: shared prediction-state codes and the two-bit counter step.
// Assumes the two-bit state is the only multi-bit state form used.
package bht_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } bht_ctr_e;

    // Saturating step of the two-bit counter toward the resolved outcome.
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] res;
        if (taken) begin
            res = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
        end else begin
            res = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
        end
        return res;
    endfunction

endpackage

// File: rtl/bht_pc_split.sv
// Module bht_pc_split: splits a word-aligned PC into table index and tag.
// Assumes the two lowest PC bits carry no branch identity.
module bht_pc_split #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = ADDR_W - IDX_W - 2
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    logic unused_low;

    // Field extraction: index above the byte offset, tag above the index.
    always_comb begin
        idx        = pc[IDX_W+1:2];
        tag        = pc[ADDR_W-1:IDX_W+2];
        unused_low = ^pc[1:0];
    end
endmodule

// File: rtl/bht_state_next.sv
// Module bht_state_next: computes the state written by an update.
// Two-bit mode saturates and allocates into a weak state; one-bit mode
// records the last outcome. Assumes old_state is meaningful only on hit.
module bht_state_next
    import bht_pkg::*;
#(
    parameter int ONE_BIT = 0,
    parameter int SW      = (ONE_BIT != 0) ? 1 : 2
) (
    input  logic          hit,
    input  logic          taken,
    input  logic [SW-1:0] old_state,
    output logic [SW-1:0] new_state
);
    generate
        if (ONE_BIT != 0) begin : g_last
            // Last-outcome state for both allocation and hit.
            always_comb new_state = taken;
        end else begin : g_sat
            // Weak allocation or saturating step on hit.
            always_comb begin
                if (!hit) begin
                    new_state = taken ? CTR_WEAK_T : CTR_WEAK_NT;
                end else begin
                    new_state = ctr_step(old_state, taken);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bht_table.sv
// Module bht_table: storage for valid, tag, target and state, with one
// combinational read port for lookup, one for the update path and one write
// port. Only the valid bits are reset; other fields are written on allocation.
module bht_table #(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 32,
    parameter int TAG_W   = 24,
    parameter int SW      = 2,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [ADDR_W-1:0]  rd_target,
    output logic [SW-1:0]      rd_state,
    input  logic [IDX_W-1:0]   ur_idx,
    output logic               ur_valid,
    output logic [TAG_W-1:0]   ur_tag,
    output logic [SW-1:0]      ur_state,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [ADDR_W-1:0]  wr_target,
    input  logic [SW-1:0]      wr_state,
    output logic [ENTRIES-1:0] valid_vec
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q    [ENTRIES];
    logic [ADDR_W-1:0]  target_q [ENTRIES];
    logic [SW-1:0]      state_q  [ENTRIES];

    // Valid bits: cleared by reset, set by any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Entry payload: tag, target and state written together.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]    <= wr_tag;
            target_q[wr_idx] <= wr_target;
            state_q[wr_idx]  <= wr_state;
        end
    end

    // Read ports: combinational, so a same-cycle write is not yet visible.
    always_comb begin
        rd_valid  = valid_q[rd_idx];
        rd_tag    = tag_q[rd_idx];
        rd_target = target_q[rd_idx];
        rd_state  = state_q[rd_idx];
        ur_valid  = valid_q[ur_idx];
        ur_tag    = tag_q[ur_idx];
        ur_state  = state_q[ur_idx];
        valid_vec = valid_q;
    end
endmodule

// File: rtl/bht_predictor.sv
// Module bht_predictor: direct-mapped branch history table for fetch.
// Lookup is combinational from lk_pc; updates land at the clock edge.
// Assumes ENTRIES is a power of two and PCs are word aligned.
module bht_predictor
    import bht_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 32,
    parameter int ONE_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic              lk_taken,
    output logic [ADDR_W-1:0] lk_target,
    output logic [ADDR_W-1:0] lk_next_pc,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W - 2;
    localparam int SW    = (ONE_BIT != 0) ? 1 : 2;

    logic [IDX_W-1:0]   lk_idx, up_idx;
    logic [TAG_W-1:0]   lk_tag, up_tag;
    logic               lk_vld_st, up_vld_st;
    logic [TAG_W-1:0]   lk_tag_st, up_tag_st;
    logic [ADDR_W-1:0]  lk_tgt_st;
    logic [SW-1:0]      lk_st, up_st_old, up_st_new;
    logic               up_hit;
    logic [ENTRIES-1:0] valid_vec;

    bht_pc_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lk_split (
        .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
    );

    bht_pc_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_up_split (
        .pc(up_pc), .idx(up_idx), .tag(up_tag)
    );

    bht_table #(
        .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .SW(SW), .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_valid(lk_vld_st), .rd_tag(lk_tag_st),
        .rd_target(lk_tgt_st), .rd_state(lk_st),
        .ur_idx(up_idx), .ur_valid(up_vld_st), .ur_tag(up_tag_st), .ur_state(up_st_old),
        .wr_en(up_valid), .wr_idx(up_idx), .wr_tag(up_tag),
        .wr_target(up_target), .wr_state(up_st_new),
        .valid_vec(valid_vec)
    );

    bht_state_next #(.ONE_BIT(ONE_BIT), .SW(SW)) u_next (
        .hit(up_hit), .taken(up_taken), .old_state(up_st_old), .new_state(up_st_new)
    );

    // Update-side match: decides between adjusting and allocating.
    always_comb up_hit = up_vld_st && (up_tag_st == up_tag);

    // Lookup result: taken only on a hit whose state has its top bit set.
    always_comb begin
        lk_hit     = lk_vld_st && (lk_tag_st == lk_tag);
        lk_taken   = lk_hit && lk_st[SW-1];
        lk_target  = lk_hit ? lk_tgt_st : '0;
        lk_next_pc = lk_taken ? lk_tgt_st : lk_pc + ADDR_W'(4);
    end
endmodule

// File: rtl/bht_predictor_chk.sv
// Module bht_predictor_chk: cycle-by-cycle properties of bht_predictor,
// attached through bind. Assumes the same parameters as the bound instance.
module bht_predictor_chk #(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 32,
    parameter int ONE_BIT = 0,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int SW      = (ONE_BIT != 0) ? 1 : 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  lk_pc,
    input logic               lk_hit,
    input logic               lk_taken,
    input logic [ADDR_W-1:0]  lk_next_pc,
    input logic               up_valid,
    input logic               up_taken,
    input logic               up_hit,
    input logic [IDX_W-1:0]   up_idx,
    input logic [SW-1:0]      up_st_old,
    input logic [SW-1:0]      up_st_new,
    input logic [ENTRIES-1:0] valid_vec
);
    p_miss_falls_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (!lk_taken && lk_next_pc == lk_pc + ADDR_W'(4)));

    p_write_validates_r5: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> valid_vec[$past(up_idx)]);

    p_reset_invalidates_r8: assert property (@(posedge clk)
        !rst_n |=> (valid_vec == '0));

    p_sat_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_hit && up_taken && up_st_old == {SW{1'b1}}) |-> up_st_new == {SW{1'b1}});

    p_sat_bottom_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_hit && !up_taken && up_st_old == '0) |-> up_st_new == '0);

    generate
        if (ONE_BIT != 0) begin : g_one
            p_last_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
                up_valid |-> up_st_new == SW'(up_taken));
        end else begin : g_two
            p_weak_alloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (up_valid && !up_hit) |-> up_st_new == (up_taken ? SW'(2) : SW'(1)));
            p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (up_valid && up_hit && up_taken && up_st_old != SW'(3)) |-> up_st_new == up_st_old + SW'(1));
            p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (up_valid && up_hit && !up_taken && up_st_old != SW'(0)) |-> up_st_new == up_st_old - SW'(1));
        end
    endgenerate
endmodule

bind bht_predictor bht_predictor_chk #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .ONE_BIT(ONE_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .lk_next_pc(lk_next_pc), .up_valid(up_valid), .up_taken(up_taken), .up_hit(up_hit),
    .up_idx(up_idx), .up_st_old(up_st_old), .up_st_new(up_st_new), .valid_vec(valid_vec)
);

// File: tb/bht_predictor_test.sv
`timescale 1ns/1ps
// Bench: small table (8 entries, 16-bit PC) in both modes side by side,
// checked against an arithmetic model of the requirements.
module bht_predictor_test;
    localparam int N  = 8;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] lk_pc = '0, up_pc = '0, up_target = '0;
    logic          up_valid = 1'b0, up_taken = 1'b0;
    logic          h2, t2, h1, t1;
    logic [AW-1:0] tg2, np2, tg1, np1;

    int n_vec = 0;
    int n_bad = 0;

    bit mv [N];
    int mtag [N];
    int mtgt [N];
    int ms2 [N];
    int ms1 [N];
    bit malloc [N];

    always #2 clk = ~clk;

    bht_predictor #(.ENTRIES(N), .ADDR_W(AW), .ONE_BIT(0)) uut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(h2), .lk_taken(t2),
        .lk_target(tg2), .lk_next_pc(np2), .up_valid(up_valid), .up_pc(up_pc),
        .up_taken(up_taken), .up_target(up_target)
    );

    bht_predictor #(.ENTRIES(N), .ADDR_W(AW), .ONE_BIT(1)) uut1 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(h1), .lk_taken(t1),
        .lk_target(tg1), .lk_next_pc(np1), .up_valid(up_valid), .up_pc(up_pc),
        .up_taken(up_taken), .up_target(up_target)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Lookup lk_pc=pc and compare both instances with the model.
    task automatic look(input logic [AW-1:0] pc, input string rq);
        int ix, tg, nxt, e_tgt;
        bit hit, k2, k1;
        lk_pc = pc;
        #1;
        ix  = int'(pc[4:2]);
        tg  = int'(pc[15:5]);
        hit = mv[ix] && (mtag[ix] == tg);
        k2  = hit && (ms2[ix] >= 2);
        k1  = hit && (ms1[ix] == 1);
        e_tgt = hit ? mtgt[ix] : 0;
        chk("R1", "hit 2b", int'(h2), int'(hit));
        chk("R1", "hit 1b", int'(h1), int'(hit));
        chk(rq, "taken 2b", int'(t2), int'(k2));
        chk("R9", "taken 1b", int'(t1), int'(k1));
        chk("R6", "target", int'(tg2), e_tgt);
        nxt = k2 ? mtgt[ix] : ((int'(pc) + 4) & 16'hFFFF);
        chk("R3", "next 2b", int'(np2), nxt);
        nxt = k1 ? mtgt[ix] : ((int'(pc) + 4) & 16'hFFFF);
        chk("R3", "next 1b", int'(np1), nxt);
    endtask

    task automatic model_write(input logic [AW-1:0] pc, input bit tk, input int tgt);
        int ix, tg;
        ix = int'(pc[4:2]);
        tg = int'(pc[15:5]);
        if (mv[ix] && mtag[ix] == tg) begin
            ms2[ix] = tk ? ((ms2[ix] == 3) ? 3 : ms2[ix] + 1) : ((ms2[ix] == 0) ? 0 : ms2[ix] - 1);
            malloc[ix] = 1'b0;
        end else begin
            mv[ix] = 1'b1;
            mtag[ix] = tg;
            ms2[ix] = tk ? 2 : 1;
            malloc[ix] = 1'b1;
        end
        ms1[ix] = tk ? 1 : 0;
        mtgt[ix] = tgt;
    endtask

    task automatic upd(input logic [AW-1:0] pc, input bit tk, input logic [AW-1:0] tgt);
        up_pc = pc;
        up_taken = tk;
        up_target = tgt;
        up_valid = 1'b1;
        @(posedge clk);
        model_write(pc, tk, int'(tgt));
        #1 up_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        for (int i = 0; i < N; i++) mv[i] = 1'b0;
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // R8 and R3: reset state, every index misses and falls through.
        for (int i = 0; i < N; i++) look(AW'(i * 4 + 16'h0300), "R8");

        // R2: weak taken allocation, then strong, then back to weak taken.
        upd(16'h0104, 1'b1, 16'h2000);
        look(16'h0104, "R2");
        upd(16'h0104, 1'b1, 16'h2000);
        look(16'h0104, "R2");
        upd(16'h0104, 1'b0, 16'h2000);
        look(16'h0104, "R2");

        // R4/R5/R6 sweep: every index, three tags (aliasing evicts), mixed outcomes.
        for (int tg = 0; tg < 3; tg++) begin
            for (int ix = 0; ix < N; ix++) begin
                for (int st = 0; st < 8; st++) begin
                    logic [AW-1:0] pc;
                    int seed;
                    bit tk;
                    pc   = {AW'(tg + 1)} << 5 | AW'(ix << 2);
                    seed = (ix * 37 + tg * 11 + 8'h5A) & 8'hFF;
                    tk   = seed[st];
                    look(pc, malloc[ix] ? "R5" : "R4");
                    upd(pc, tk, AW'(16'h1000 + ix * 256 + st * 16 + tg * 4));
                end
                look({AW'(tg + 1)} << 5 | AW'(ix << 2), malloc[ix] ? "R5" : "R4");
            end
        end

        // R7: same-cycle lookup and update of one entry.
        upd(16'h0418, 1'b0, 16'h3000);
        #1;
        lk_pc = 16'h0418;
        up_pc = 16'h0418;
        up_taken = 1'b1;
        up_target = 16'h3400;
        up_valid = 1'b1;
        #1;
        chk("R7", "old taken", int'(t2), 0);
        chk("R7", "old target", int'(tg2), 16'h3000);
        @(posedge clk);
        model_write(16'h0418, 1'b1, 16'h3400);
        #1 up_valid = 1'b0;
        #1;
        chk("R7", "new taken", int'(t2), 1);
        chk("R7", "new target", int'(tg2), 16'h3400);

        // R8: mid-run reset drops previously valid entries.
        do_reset();
        look(16'h0418, "R8");
        look(16'h0104, "R8");

        // R10: three-iteration loop branch replayed four times.
        for (int run = 1; run <= 4; run++) begin
            for (int it = 1; it <= 3; it++) begin
                bit tk, mis2, mis1;
                tk = (it < 3);
                lk_pc = 16'h0040;
                #1;
                mis2 = (t2 != tk);
                mis1 = (t1 != tk);
                if (run >= 2) begin
                    chk("R10", "2b mispredict", int'(mis2), int'(it == 3));
                    chk("R10", "1b mispredict", int'(mis1), int'(it == 1 || it == 3));
                end
                upd(16'h0040, tk, 16'h0030);
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule